// File: doc/BRIEF.md
# Firmware Write-Protect Control Register

This block is an 8-bit configuration register that decides how the host may reach the firmware flash region. It holds three fields. A two-bit read-policy field selects how the SPI read path treats host fetches: caching only, direct reads with no caching, or caching with prefetch. A lock bit can be set but not cleared by software. A write-enable bit opens the region to write cycles.

Host firmware cycles pass through a combinational gate. Read cycles always pass. Write cycles pass only while the write enable is set. When software raises the write enable while the lock is already set, the block emits a one-cycle management-interrupt pulse, so trusted handler code can vet every unlock. The block has two resets. The block reset clears the policy and the write enable but keeps the lock. The platform reset clears everything.

The block also decodes the policy field into cache-enable and prefetch-enable levels. It pulses a cache-invalidate output when the policy is switched to direct reads, and it pulses an error output when software writes the reserved policy code.

Top module: `fwprot_ctrl`

## Requirements
- R1: While `plat_rst` is high at a clock edge, the whole register is cleared. After that edge `cfg_rdata` reads 00h and every pulse output is low.
- R2: While `rst` is high at a clock edge, the policy field (bits 3:2) and the write enable (bit 0) are cleared, and the lock (bit 1) keeps its value.
- R3: Bits 7:4 of `cfg_rdata` always read zero, and the write data in those bits has no effect.
- R4: The policy field sits at bits 3:2. `cache_en` is high for codes 00 and 10. `prefetch_en` is high only for code 10.
- R5: A write of code 11 to bits 3:2 leaves the policy field unchanged and drives `pol_err` high for exactly the cycle after the write edge.
- R6: A write that changes the policy field to 01 from any other code drives `cache_inval` high for exactly the cycle after the write edge. A write of 01 when the field already holds 01 gives no pulse.
- R7: The lock is bit 1. Writing 1 sets it. Writing 0 leaves it unchanged, so only a reset can clear it (see R1 and R2 for which reset does so).
- R8: The write enable is bit 0. `fw_grant` = `fw_req_valid` and (not `fw_req_write` or write enable), in the same cycle as the request.
- R9: A write that takes bit 0 from 0 to 1, while the lock held before that write is 1, drives `smi_pulse` high for exactly the cycle after the write edge. The lock value set by that same write does not count.
- R10: No `smi_pulse` follows a write that sets bit 0 while the prior lock is 0. None follows a write that keeps bit 0 at 1 when it was already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous block reset, active high; keeps the lock |
| plat_rst | input | 1 | Synchronous platform reset, active high; clears everything |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Current register contents |
| fw_req_valid | input | 1 | Host firmware-region cycle present |
| fw_req_write | input | 1 | The host cycle is a write |
| fw_grant | output | 1 | The host cycle may proceed |
| cache_en | output | 1 | Read-buffer caching enabled |
| prefetch_en | output | 1 | Read prefetching enabled |
| cache_inval | output | 1 | One-cycle cache-invalidate pulse |
| pol_err | output | 1 | One-cycle reserved-policy-code pulse |
| smi_pulse | output | 1 | One-cycle management-interrupt pulse |

## Verification
The bench drives inputs on the falling edge. After a write, the register readback and both decode levels change at the next rising edge, and the three pulses are high only in the cycle after that edge. So the bench samples these at the falling edge one half-cycle after the write edge, then samples again one cycle later to confirm the pulses have dropped. The grant is combinational, so it is checked a few nanoseconds after the request inputs change, within the same low phase. Resets follow the same one-edge timing as writes.

// File: rtl/fwprot_pkg.sv
package fwprot_pkg;

    localparam int REG_W    = 8;
    localparam int POL_W    = 2;
    localparam int POL_LSB  = 2;
    localparam int LOCK_BIT = 1;
    localparam int WEN_BIT  = 0;
    localparam int USED_W   = POL_LSB + POL_W;

    typedef enum logic [POL_W-1:0] {
        POL_CACHE_ONLY = 2'b00,
        POL_DIRECT     = 2'b01,
        POL_PREFETCH   = 2'b10,
        POL_INVALID    = 2'b11
    } rd_pol_e;

    typedef struct packed {
        rd_pol_e pol;
        logic    lock;
        logic    wen;
    } ctl_t;

    typedef struct packed {
        logic smi;
        logic inval;
        logic err;
    } evt_t;

    function automatic ctl_t unpack_wr(input logic [USED_W-1:0] d);
        ctl_t c;
        c.pol  = rd_pol_e'(d[POL_LSB +: POL_W]);
        c.lock = d[LOCK_BIT];
        c.wen  = d[WEN_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_rd(input ctl_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[POL_LSB +: POL_W] = c.pol;
        r[LOCK_BIT]         = c.lock;
        r[WEN_BIT]          = c.wen;
        return r;
    endfunction

    function automatic logic pol_caches(input rd_pol_e p);
        return (p == POL_CACHE_ONLY) || (p == POL_PREFETCH);
    endfunction

    function automatic logic pol_prefetches(input rd_pol_e p);
        return p == POL_PREFETCH;
    endfunction

endpackage

// File: rtl/fwprot_regs.sv
module fwprot_regs
    import fwprot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic plat_rst,
    input  logic wr,
    input  ctl_t req,
    output ctl_t cur
);

    always_ff @(posedge clk) begin
        if (plat_rst) begin
            cur <= '0;
        end else if (rst) begin
            cur.pol <= POL_CACHE_ONLY;
            cur.wen <= 1'b0;
        end else if (wr) begin
            if (req.pol != POL_INVALID)
                cur.pol <= req.pol;
            cur.lock <= cur.lock | req.lock;
            cur.wen  <= req.wen;
        end
    end

endmodule

// File: rtl/fwprot_events.sv
module fwprot_events
    import fwprot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic plat_rst,
    input  logic wr,
    input  ctl_t cur,
    input  ctl_t req,
    output evt_t evt
);

    evt_t nxt;

    always_comb begin
        nxt       = '0;
        nxt.smi   = wr && req.wen && !cur.wen && cur.lock;
        nxt.inval = wr && (req.pol == POL_DIRECT) && (cur.pol != POL_DIRECT);
        nxt.err   = wr && (req.pol == POL_INVALID);
    end

    always_ff @(posedge clk) begin
        if (plat_rst || rst)
            evt <= '0;
        else
            evt <= nxt;
    end

endmodule

// File: rtl/fwprot_access.sv
module fwprot_access
    import fwprot_pkg::*;
(
    input  ctl_t cur,
    input  logic req_valid,
    input  logic req_write,
    output logic grant,
    output logic cache_en,
    output logic prefetch_en
);

    always_comb begin
        grant       = req_valid && (!req_write || cur.wen);
        cache_en    = pol_caches(cur.pol);
        prefetch_en = pol_prefetches(cur.pol);
    end

endmodule

// File: rtl/fwprot_ctrl.sv
module fwprot_ctrl
    import fwprot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             plat_rst,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             fw_req_valid,
    input  logic             fw_req_write,
    output logic             fw_grant,
    output logic             cache_en,
    output logic             prefetch_en,
    output logic             cache_inval,
    output logic             pol_err,
    output logic             smi_pulse
);

    ctl_t req;
    ctl_t cur;
    evt_t evt;

    assign req = unpack_wr(cfg_wdata[USED_W-1:0]);

    fwprot_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .plat_rst (plat_rst),
        .wr       (cfg_wr),
        .req      (req),
        .cur      (cur)
    );

    fwprot_events u_events (
        .clk      (clk),
        .rst      (rst),
        .plat_rst (plat_rst),
        .wr       (cfg_wr),
        .cur      (cur),
        .req      (req),
        .evt      (evt)
    );

    fwprot_access u_access (
        .cur         (cur),
        .req_valid   (fw_req_valid),
        .req_write   (fw_req_write),
        .grant       (fw_grant),
        .cache_en    (cache_en),
        .prefetch_en (prefetch_en)
    );

    assign cfg_rdata   = pack_rd(cur);
    assign cache_inval = evt.inval;
    assign pol_err     = evt.err;
    assign smi_pulse   = evt.smi;

endmodule

// File: rtl/fwprot_ctrl_chk.sv
module fwprot_ctrl_chk
    import fwprot_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             plat_rst,
    input logic             cfg_wr,
    input logic [REG_W-1:0] cfg_wdata,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             fw_req_valid,
    input logic             fw_req_write,
    input logic             fw_grant,
    input logic             cache_en,
    input logic             prefetch_en,
    input logic             cache_inval,
    input logic             pol_err,
    input logic             smi_pulse
);

    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (plat_rst)
        cfg_rdata[REG_W-1:USED_W] == '0);

    assert_pol_never_bad_R5: assert property (@(posedge clk) disable iff (plat_rst)
        cfg_rdata[POL_LSB +: POL_W] != POL_INVALID);

    assert_err_keeps_pol_R5: assert property (@(posedge clk) disable iff (plat_rst || rst)
        pol_err |-> cfg_rdata[POL_LSB +: POL_W] == $past(cfg_rdata[POL_LSB +: POL_W]));

    assert_prefetch_needs_cache_R4: assert property (@(posedge clk) disable iff (plat_rst)
        prefetch_en |-> cache_en);

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (plat_rst)
        cfg_rdata[LOCK_BIT] |=> cfg_rdata[LOCK_BIT]);

    assert_write_blocked_R8: assert property (@(posedge clk) disable iff (plat_rst)
        (fw_req_write && !cfg_rdata[WEN_BIT]) |-> !fw_grant);

    assert_read_passes_R8: assert property (@(posedge clk) disable iff (plat_rst)
        (fw_req_valid && !fw_req_write) |-> fw_grant);

    assert_smi_state_R9: assert property (@(posedge clk) disable iff (plat_rst || rst)
        smi_pulse |-> (cfg_rdata[LOCK_BIT] && cfg_rdata[WEN_BIT]));

    assert_smi_one_cycle_R9: assert property (@(posedge clk) disable iff (plat_rst || rst)
        smi_pulse |=> !smi_pulse);

    assert_inval_target_R6: assert property (@(posedge clk) disable iff (plat_rst || rst)
        cache_inval |-> cfg_rdata[POL_LSB +: POL_W] == POL_DIRECT);

endmodule

bind fwprot_ctrl fwprot_ctrl_chk u_chk (.*);

// File: tb/tb_fwprot_ctrl.sv
module tb_fwprot_ctrl;

    logic       clk = 1'b0;
    logic       rst, plat_rst, cfg_wr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       fw_req_valid, fw_req_write, fw_grant;
    logic       cache_en, prefetch_en, cache_inval, pol_err, smi_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [1:0] m_pol;
    logic       m_lock, m_wen;

    always #10 clk = ~clk;

    fwprot_ctrl dut (.*);

    function automatic logic exp_cache(input logic [1:0] p);
        return (p == 2'b00) || (p == 2'b10);
    endfunction

    function automatic logic exp_pref(input logic [1:0] p);
        return p == 2'b10;
    endfunction

    function automatic logic [7:0] exp_rd();
        return {4'h0, m_pol, m_lock, m_wen};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk({tag, " R3 reserved bits"}, {28'h0, cfg_rdata[7:4]}, 0);
        chk({tag, " readback"}, {24'h0, cfg_rdata}, {24'h0, exp_rd()});
        chk({tag, " R4 cache_en"}, {31'h0, cache_en}, {31'h0, exp_cache(m_pol)});
        chk({tag, " R4 prefetch_en"}, {31'h0, prefetch_en}, {31'h0, exp_pref(m_pol)});
    endtask

    task automatic check_quiet(input string tag);
        chk({tag, " R9 smi low"}, {31'h0, smi_pulse}, 0);
        chk({tag, " R6 inval low"}, {31'h0, cache_inval}, 0);
        chk({tag, " R5 err low"}, {31'h0, pol_err}, 0);
    endtask

    // called at a falling edge
    task automatic do_write(input logic [7:0] d, input string tag);
        logic e_smi, e_inv, e_err;
        e_smi = d[0] && !m_wen && m_lock;
        e_inv = (d[3:2] == 2'b01) && (m_pol != 2'b01);
        e_err = (d[3:2] == 2'b11);
        if (!e_err) m_pol = d[3:2];
        m_lock = m_lock | d[1];
        m_wen  = d[0];
        cfg_wr = 1'b1;
        cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_wdata = 8'($urandom);
        chk({tag, " R9/R10 smi"}, {31'h0, smi_pulse}, {31'h0, e_smi});
        chk({tag, " R6 inval"}, {31'h0, cache_inval}, {31'h0, e_inv});
        chk({tag, " R5 err"}, {31'h0, pol_err}, {31'h0, e_err});
        check_state(tag);
        @(negedge clk);
        check_quiet({tag, " pulse width"});
    endtask

    task automatic do_reset(input logic core, input logic plat, input string tag);
        rst = core;
        plat_rst = plat;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        plat_rst = 1'b0;
        m_pol = 2'b00;
        m_wen = 1'b0;
        if (plat) m_lock = 1'b0;
        check_state(tag);
        check_quiet(tag);
    endtask

    task automatic gate(input logic v, input logic w);
        fw_req_valid = v;
        fw_req_write = w;
        #1;
        chk("R8 grant", {31'h0, fw_grant}, {31'h0, v && (!w || m_wen)});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; plat_rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = 8'h00;
        fw_req_valid = 1'b0; fw_req_write = 1'b0;
        m_pol = 2'b00; m_lock = 1'b0; m_wen = 1'b0;
        @(negedge clk);
        do_reset(1'b1, 1'b1, "R1 power-up");
        chk("R1 readback zero", {24'h0, cfg_rdata}, 0);

        do_write(8'hF0, "R3 high bits ignored");
        do_write(8'h04, "R6 switch to direct");
        do_write(8'h04, "R6 direct again");
        do_write(8'h0C, "R5 reserved code");
        do_write(8'h08, "R4 prefetch");
        do_write(8'h0C, "R5 reserved from prefetch");
        gate(1'b1, 1'b1);
        do_write(8'h01, "R10 wen without lock");
        gate(1'b1, 1'b1);
        do_write(8'h00, "R8 close");
        gate(1'b1, 1'b1);
        gate(1'b1, 1'b0);
        gate(1'b0, 1'b1);
        do_write(8'h03, "R9 lock and wen together");
        do_write(8'h00, "R7 lock survives zero");
        do_write(8'h01, "R9 locked raise");
        do_write(8'h01, "R10 already set");
        do_reset(1'b1, 1'b0, "R2 core reset");
        chk("R2 lock kept", {31'h0, cfg_rdata[1]}, 1);
        do_write(8'h05, "R9 raise after core reset");
        do_reset(1'b0, 1'b1, "R1 platform reset");
        do_write(8'h01, "R10 lock cleared");

        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = int'($urandom % 20);
            if (sel == 0)
                do_reset(1'b1, 1'b0, "R2 random core reset");
            else if (sel == 1)
                do_reset(1'b0, 1'b1, "R1 random platform reset");
            else if (sel < 6)
                gate(1'($urandom), 1'($urandom));
            else
                do_write(8'($urandom), "random write");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule